// File: doc/BRIEF.md
# Carry-Save-Input Unsigned Multiplier

This block multiplies an unsigned operand held in redundant carry-save form (a pair of N-bit vectors whose arithmetic sum is the operand value) by an ordinary M-bit unsigned binary word. Neither operand nor the result passes through a carry-propagate adder. Expressions such as (p + q) * r can therefore be evaluated with no internal carry ripple. The result leaves as a sum vector and a carry vector, and a downstream stage absorbs them directly.

The redundant operand first passes through one row of half adders. Each bit position then becomes a digit in {0, 1, 2}, encoded as two flags that are never both set. Each digit selects its partial-product row with a plain OR of two mutually exclusive gated copies of the binary operand. A tree of 4:2 compressors, with a full-adder row for leftovers, reduces all rows to exactly two. The block is purely combinational. All arithmetic is modulo 2^(N+M+1), and that width holds the largest possible product without loss.

Top module: `csm_mult`

## Requirements
- R1: The sum of `prod_sum_o` and `prod_carry_o`, taken modulo 2^(N+M+1), equals (`op_sum_i` + `op_carry_i`) * `op_bin_i`.
- R2: Both outputs are N+M+1 bits wide. The largest product (2^(N+1)-2)*(2^M-1) is represented exactly: with N=M=4 and all inputs all-ones, the two outputs add to 450.
- R3: For each bit position i, the recoding row produces two flags: a weight-1 flag equal to the XOR of the two operand bits and a weight-2 flag equal to their AND. The two flags are never both 1, and together they hold the same value as the two input bits.
- R4: Partial-product row i is the binary operand shifted left by i when the weight-1 flag is set, shifted left by i+1 when the weight-2 flag is set, and zero otherwise. The two gated terms merged by the OR never both carry a 1 in the same column.
- R5: Every compression step (4:2 group or 3:2 row) preserves the modulo-2^(N+M+1) sum of its rows. The whole tree preserves the sum of all partial-product rows.
- R6: When `op_bin_i` is zero, both outputs are zero.
- R7: When both carry-save vectors are zero, both outputs are zero.
- R8: Exchanging `op_sum_i` and `op_carry_i` leaves both outputs bit-for-bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sum_i | input | N | Sum vector of the carry-save operand |
| op_carry_i | input | N | Carry vector of the carry-save operand, same weights as the sum vector |
| op_bin_i | input | M | Unsigned binary operand |
| prod_sum_o | output | N+M+1 | Sum vector of the carry-save product |
| prod_carry_o | output | N+M+1 | Carry vector of the carry-save product |

## Verification
The in-line assertions assume that every input bit holds a defined 0 or 1 whenever the combinational logic settles. They also assume that the two carry-save vectors carry equal weights per position, so their plain sum is the operand value. The stimulus applies only fully defined vectors, changed between clock edges and held steady until the outputs are sampled. For the four-by-four configuration it sweeps every triple of sum vector, carry vector and binary operand. A sixteen-by-sixteen instance receives pseudo-random vectors, together with all-ones and all-zero corners.

// File: rtl/csm_pkg.sv
// Package csm_pkg
// Shared elaboration-time helpers for the carry-save-input multiplier.
// Assumes row counts are small (at most a few dozen rows).
package csm_pkg;

    // Number of rows left after one compression level over r rows.
    function automatic int next_rows(input int r);
        int rem;
        rem = r % 4;
        return (r / 4) * 2 + ((rem == 3) ? 2 : rem);
    endfunction

    // Row count after l compression levels starting from n rows.
    function automatic int rows_at(input int n, input int l);
        int r;
        r = n;
        for (int k = 0; k < l; k++) begin
            r = next_rows(r);
        end
        return r;
    endfunction

    // Number of levels needed until at most two rows remain.
    function automatic int tree_levels(input int n);
        int r;
        int l;
        r = n;
        l = 0;
        while (r > 2) begin
            r = next_rows(r);
            l++;
        end
        return l;
    endfunction

endpackage

// File: rtl/csm_recode.sv
// Module csm_recode
// One row of half adders that turns a carry-save operand into a digit
// vector. Digit i = one_o[i] + 2*two_o[i], in {0,1,2}.
// Assumes both input vectors carry identical bit weights.
module csm_recode #(
    parameter int N = 4
) (
    input  logic [N-1:0] vec_a_i,
    input  logic [N-1:0] vec_b_i,
    output logic [N-1:0] one_o,
    output logic [N-1:0] two_o
);

    // Half-adder row: XOR gives weight-1 flag, AND gives weight-2 flag.
    always_comb begin
        one_o = vec_a_i ^ vec_b_i;
        two_o = vec_a_i & vec_b_i;
    end

    // Checks that the digit flags are exclusive and keep the operand value.
    always_comb begin
        assert_digit_exclusive_R3: assert ((one_o & two_o) == '0)
            else $error("R3: digit flags overlap");
        assert_digit_value_R3: assert (
            ({1'b0, one_o} + {two_o, 1'b0}) ==
            ({1'b0, vec_a_i} + {1'b0, vec_b_i}))
            else $error("R3: recoded value differs from operand");
    end

endmodule

// File: rtl/csm_ppgen.sv
// Module csm_ppgen
// Builds N partial-product rows, each W bits wide, from the digit flags
// and the binary operand. Row i holds digit_i * bin * 2^i.
// Assumes one_i and two_i are never both set in the same position.
module csm_ppgen #(
    parameter int N = 4,
    parameter int M = 4,
    parameter int W = N + M + 1
) (
    input  logic [N-1:0]   one_i,
    input  logic [N-1:0]   two_i,
    input  logic [M-1:0]   bin_i,
    output logic [N*W-1:0] rows_o
);

    logic [W-1:0] bin_ext;

    // Zero-extend the binary operand to the product width.
    always_comb bin_ext = W'(bin_i);

    for (genvar i = 0; i < N; i++) begin : g_row
        logic [W-1:0] term_one;
        logic [W-1:0] term_two;

        // Gate the two candidate shifts by the digit flags.
        always_comb begin
            term_one = {W{one_i[i]}} & (bin_ext << i);
            term_two = {W{two_i[i]}} & (bin_ext << (i + 1));
        end

        // Merge the mutually exclusive terms with a plain OR.
        always_comb rows_o[i*W +: W] = term_one | term_two;

        // Checks that the OR never merges two ones in a column.
        always_comb begin
            assert_pp_exclusive_R4: assert ((term_one & term_two) == '0)
                else $error("R4: partial-product terms collide in row %0d", i);
        end
    end

endmodule

// File: rtl/csm_comp42.sv
// Module csm_comp42
// Row-wise 4:2 compressor: four W-bit rows in, two rows out, with the
// same sum modulo 2^W. The inner column carry does not depend on the
// incoming column carry, so there is no ripple across columns.
// Assumes inputs are defined; bits above W-1 are discarded.
module csm_comp42 #(
    parameter int W = 9
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);

    logic [W-1:0] s1;
    logic [W-1:0] x_carry;

    // First full-adder layer; its majority output moves one column up.
    always_comb begin
        s1      = a_i ^ b_i ^ c_i;
        x_carry = ((a_i & b_i) | (a_i & c_i) | (b_i & c_i)) << 1;
    end

    // Second full-adder layer folds in the fourth row and the column carry.
    always_comb begin
        sum_o   = s1 ^ d_i ^ x_carry;
        carry_o = ((s1 & d_i) | (s1 & x_carry) | (d_i & x_carry)) << 1;
    end

    // Checks that the compressor keeps the modular row sum.
    always_comb begin
        assert_comp42_sum_R5: assert (
            W'(sum_o + carry_o) == W'(a_i + b_i + c_i + d_i))
            else $error("R5: 4:2 compressor lost value");
    end

endmodule

// File: rtl/csm_tree.sv
// Module csm_tree
// Reduces N partial-product rows to two rows using levels of 4:2
// compressor groups; three leftover rows pass through a 3:2 row,
// one or two leftover rows pass straight through.
// Assumes N >= 1; a single row yields a zero carry output.
module csm_tree #(
    parameter int N = 4,
    parameter int W = 9
) (
    input  logic [N*W-1:0] rows_i,
    output logic [W-1:0]   sum_o,
    output logic [W-1:0]   carry_o
);

    localparam int LV   = csm_pkg::tree_levels(N);
    localparam int RFIN = csm_pkg::rows_at(N, LV);

    for (genvar lv = 0; lv <= LV; lv++) begin : stg
        localparam int RO = csm_pkg::rows_at(N, lv);
        logic [W-1:0] r [RO];

        if (lv == 0) begin : g_load
            for (genvar j = 0; j < RO; j++) begin : g_ld
                // Unpack the incoming partial-product rows.
                assign r[j] = rows_i[j*W +: W];
            end
        end else begin : g_reduce
            localparam int RI = csm_pkg::rows_at(N, lv - 1);
            localparam int G4 = RI / 4;
            localparam int RM = RI % 4;

            for (genvar g = 0; g < G4; g++) begin : g_grp
                csm_comp42 #(.W(W)) u_c42 (
                    .a_i     (stg[lv-1].r[4*g]),
                    .b_i     (stg[lv-1].r[4*g+1]),
                    .c_i     (stg[lv-1].r[4*g+2]),
                    .d_i     (stg[lv-1].r[4*g+3]),
                    .sum_o   (r[2*g]),
                    .carry_o (r[2*g+1])
                );
            end

            if (RM == 3) begin : g_fa
                logic [W-1:0] fa_a;
                logic [W-1:0] fa_b;
                logic [W-1:0] fa_c;
                // Gather the three leftover rows for the 3:2 row.
                always_comb begin
                    fa_a = stg[lv-1].r[4*G4];
                    fa_b = stg[lv-1].r[4*G4+1];
                    fa_c = stg[lv-1].r[4*G4+2];
                end
                // Full-adder row: parity stays, majority shifts up one column.
                always_comb begin
                    r[2*G4]   = fa_a ^ fa_b ^ fa_c;
                    r[2*G4+1] = ((fa_a & fa_b) | (fa_a & fa_c) | (fa_b & fa_c)) << 1;
                end
                // Checks that the 3:2 row keeps the modular row sum.
                always_comb begin
                    assert_csa32_sum_R5: assert (
                        W'(r[2*G4] + r[2*G4+1]) == W'(fa_a + fa_b + fa_c))
                        else $error("R5: 3:2 row lost value");
                end
            end else begin : g_pass
                for (genvar j = 0; j < RM; j++) begin : g_p
                    // Leftover rows skip this level unchanged.
                    assign r[2*G4+j] = stg[lv-1].r[4*G4+j];
                end
            end
        end
    end

    // Drive the two output vectors from the last level.
    if (RFIN >= 2) begin : g_two
        assign sum_o   = stg[LV].r[0];
        assign carry_o = stg[LV].r[1];
    end else begin : g_one
        assign sum_o   = stg[LV].r[0];
        assign carry_o = '0;
    end

    logic [W-1:0] row_total;

    // Reference modular sum of all incoming rows, for the tree check.
    always_comb begin
        row_total = '0;
        for (int j = 0; j < N; j++) begin
            row_total = row_total + rows_i[j*W +: W];
        end
    end

    // Checks that the whole tree keeps the modular sum of its rows.
    always_comb begin
        assert_tree_sum_R5: assert (W'(sum_o + carry_o) == row_total)
            else $error("R5: tree output does not match row sum");
    end

endmodule

// File: rtl/csm_mult.sv
// Module csm_mult
// Combinational unsigned multiplier: carry-save operand (two N-bit
// vectors) times binary operand (M bits), product in carry-save form,
// N+M+1 bits wide, modulo 2^(N+M+1).
// Assumes defined inputs; no clock, no state.
module csm_mult #(
    parameter int N = 4,
    parameter int M = 4
) (
    input  logic [N-1:0]     op_sum_i,
    input  logic [N-1:0]     op_carry_i,
    input  logic [M-1:0]     op_bin_i,
    output logic [N+M:0]     prod_sum_o,
    output logic [N+M:0]     prod_carry_o
);

    localparam int W = N + M + 1;

    logic [N-1:0]   dig_one;
    logic [N-1:0]   dig_two;
    logic [N*W-1:0] pp_rows;

    csm_recode #(.N(N)) u_recode (
        .vec_a_i (op_sum_i),
        .vec_b_i (op_carry_i),
        .one_o   (dig_one),
        .two_o   (dig_two)
    );

    csm_ppgen #(.N(N), .M(M), .W(W)) u_ppgen (
        .one_i  (dig_one),
        .two_i  (dig_two),
        .bin_i  (op_bin_i),
        .rows_o (pp_rows)
    );

    csm_tree #(.N(N), .W(W)) u_tree (
        .rows_i  (pp_rows),
        .sum_o   (prod_sum_o),
        .carry_o (prod_carry_o)
    );

    logic [2*W-1:0] full_prod;

    // Wide product of the port values, used only by the checks below.
    always_comb begin
        full_prod = ((2*W)'(op_sum_i) + (2*W)'(op_carry_i)) * (2*W)'(op_bin_i);
    end

    // Checks the port-level product and that it never exceeds W bits.
    always_comb begin
        assert_product_R1: assert (W'(prod_sum_o + prod_carry_o) == W'(full_prod))
            else $error("R1: carry-save product wrong");
        assert_no_overflow_R2: assert ((full_prod >> W) == '0)
            else $error("R2: product exceeds output width");
        assert_zero_bin_R6: assert (op_bin_i != '0 ||
            (prod_sum_o == '0 && prod_carry_o == '0))
            else $error("R6: zero binary operand gave nonzero output");
    end

endmodule

// File: tb/tb_csm_mult.sv
module tb_csm_mult;

    localparam int N  = 4;
    localparam int M  = 4;
    localparam int W  = N + M + 1;
    localparam int NW = 16;
    localparam int MW = 16;
    localparam int WW = NW + MW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [N-1:0] xs, xc;
    logic [M-1:0] yb;
    logic [W-1:0] ps, pc;

    logic [NW-1:0] wxs, wxc;
    logic [MW-1:0] wyb;
    logic [WW-1:0] wps, wpc;

    csm_mult #(.N(N), .M(M)) dut (
        .op_sum_i(xs), .op_carry_i(xc), .op_bin_i(yb),
        .prod_sum_o(ps), .prod_carry_o(pc)
    );

    csm_mult #(.N(NW), .M(MW)) dut_wide (
        .op_sum_i(wxs), .op_carry_i(wxc), .op_bin_i(wyb),
        .prod_sum_o(wps), .prod_carry_o(wpc)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_small(input int a, input int b, input int c);
        @(negedge clk);
        xs = N'(a); xc = N'(b); yb = M'(c);
        @(posedge clk);
        #2;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        longint exp_v;
        logic [W-1:0] s0, c0;
        xs = '0; xc = '0; yb = '0;
        wxs = '0; wxc = '0; wyb = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #2;
        // Idle state with all-zero inputs: outputs zero (R7).
        check("R7 idle", longint'(ps) | longint'(pc), 0);

        // Exhaustive sweep of the small configuration (R1, R3, R4, R5, R6, R7, R8).
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 16; c++) begin
                    apply_small(a, b, c);
                    exp_v = ((a + b) * c) % (1 << W);
                    check("R1", (longint'(ps) + longint'(pc)) % (1 << W), exp_v);
                    if (c == 0)
                        check("R6", longint'(ps) | longint'(pc), 0);
                    if (a == 0 && b == 0)
                        check("R7", longint'(ps) | longint'(pc), 0);
                    if (a != b && c % 5 == 1) begin
                        s0 = ps; c0 = pc;
                        apply_small(b, a, c);
                        check("R8 sum", longint'(ps), longint'(s0));
                        check("R8 carry", longint'(pc), longint'(c0));
                    end
                end
            end
        end

        // Largest product must be exact (R2).
        apply_small(15, 15, 15);
        check("R2 max", longint'(ps) + longint'(pc), 450);

        // Wide configuration: corners then pseudo-random vectors (R1, R2).
        @(negedge clk);
        wxs = '1; wxc = '1; wyb = '1;
        @(posedge clk); #2;
        exp_v = ((longint'(1) << (NW + 1)) - 2) * ((longint'(1) << MW) - 1);
        check("R2 wide max", (longint'(wps) + longint'(wpc)) % (longint'(1) << WW), exp_v);
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            wxs = NW'($urandom); wxc = NW'($urandom); wyb = MW'($urandom);
            if (k % 97 == 0) wyb = '0;
            @(posedge clk); #2;
            exp_v = ((longint'(wxs) + longint'(wxc)) * longint'(wyb)) % (longint'(1) << WW);
            check("R1 wide", (longint'(wps) + longint'(wpc)) % (longint'(1) << WW), exp_v);
        end

        done = 1'b1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule